// File: doc/BRIEF.md
# Single-Instruction Subtract-and-Branch Processor

This block is a small multicycle processor whose whole instruction set is one operation, so it carries no opcode and no decode stage. Every instruction occupies three consecutive memory words: the address of a subtrahend, the address of a minuend, and a branch target. The processor reads both operands and subtracts the first from the second. It writes the difference back over the second operand. When the difference is zero or negative, taken as a signed two's complement value, it jumps to the target. Otherwise it moves on to the next triple.

A step counter sequences the work over twelve single-cycle steps, all through one shared memory port. Each step code drives its own set of control signals for the PC, the operand pointer registers, the operand value register, the result register and the subtractor. When the last step finishes, the counter wraps to zero. At the start of every instruction the PC is compared with zero, and a zero PC stops the processor for good until the next reset. Programs build other operations out of the one instruction. For example, jumping with both operand addresses equal clears that word and always branches, which gives an unconditional jump. An add is built from two subtractions through a zeroed temporary.

The memory port is a plain synchronous single-port interface with a fixed one-cycle read latency and no back-pressure. An address driven in one cycle returns its word on the read-data input in the following cycle. A write takes effect at the clock edge where write enable is high. Debug outputs expose the PC and the step code.

Top module: `onei_cpu`

## Requirements
- R1: While reset (active low) is held, the debug PC reads 1, the step code reads 0, halted is low and write enable is low.
- R2: Each instruction (A, B, P) stores mem[B] − mem[A], wrapped to 16 bits, into mem[B].
- R3: When the stored difference is zero or has its sign bit (bit 15) set, the next instruction is fetched from P. A difference that wrapped past the most negative value to a positive one does not branch.
- R4: When the stored difference is strictly positive, execution continues at the triple that follows, at PC + 3.
- R5: An instruction whose two operand addresses are equal clears that word and always branches, acting as an unconditional jump.
- R6: When the PC is 0 at the start of an instruction, halted rises one cycle later, the step code becomes 15, and the block then makes no memory write until reset.
- R7: An instruction takes exactly twelve cycles with step codes 0 through 11 in order, then wraps to 0, and makes exactly one memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | ADDR_W | Memory address for the read or write of this cycle |
| mem_wdata | output | DATA_W | Write data (the stored difference) |
| mem_we | output | 1 | Write enable; high for one cycle per instruction |
| mem_rdata | input | DATA_W | Read data for the address driven in the previous cycle |
| halted | output | 1 | High once a zero PC has been reached |
| dbg_pc | output | ADDR_W | Current program counter |
| dbg_step | output | 4 | Step code: 0..11 while running, 15 when halted |

## Verification
Small programs are run from a zeroed memory image and the final memory words are compared. These programs are an add through a zero temporary, a move built from three subtractions, and a jump to address 0. The branch decision is tried with a positive difference, a negative difference, an exact zero and a difference that wraps from the most negative value to a positive one. Marker instructions at both possible successors show which path ran. Write counts tell a missed or doubled write-back apart from a wrong value, and a sampled run of step codes separates a skipped or repeated step from a wrong branch. After halt the bench keeps the clock running and watches for stray writes.

// File: rtl/onei_pkg.sv
package onei_pkg;
  // Step codes; the debug port exposes these values directly.
  typedef enum logic [3:0] {
    ST_FA   = 4'd0,   // drive PC: first operand pointer; zero-PC check
    ST_CA   = 4'd1,   // capture first pointer, PC+1
    ST_FVA  = 4'd2,   // drive first pointer
    ST_CVA  = 4'd3,   // capture first value
    ST_FB   = 4'd4,   // drive PC: second operand pointer
    ST_CB   = 4'd5,   // capture second pointer, PC+1
    ST_FVB  = 4'd6,   // drive second pointer
    ST_CVB  = 4'd7,   // capture second value, subtract
    ST_WB   = 4'd8,   // write difference back
    ST_FP   = 4'd9,   // drive PC: target
    ST_CP   = 4'd10,  // capture target, PC+1
    ST_JMP  = 4'd11,  // conditional load of PC
    ST_HALT = 4'd15
  } step_e;
endpackage

// File: rtl/onei_alu.sv
module onei_alu #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] minuend,
  input  logic [DATA_W-1:0] subtrahend,
  input  logic [DATA_W-1:0] stored,
  output logic [DATA_W-1:0] diff,
  output logic              le_zero
);
  assign diff    = minuend - subtrahend;
  // Condition taken from the registered result, not the live difference.
  assign le_zero = stored[DATA_W-1] | (stored == '0);
endmodule

// File: rtl/onei_seq.sv
module onei_seq
  import onei_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pc_zero,
  output step_e step,
  output logic  halted
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step <= ST_FA;
    end else begin
      case (step)
        ST_FA:   step <= pc_zero ? ST_HALT : ST_CA;
        ST_JMP:  step <= ST_FA;
        ST_HALT: step <= ST_HALT;
        default: step <= step_e'(4'(step) + 4'd1);
      endcase
    end
  end

  assign halted = (step == ST_HALT);

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R6
  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_JMP) |=> (step == ST_FA)); // R7
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (step != ST_FA && step != ST_JMP && step != ST_HALT)
      |=> (4'(step) == 4'($past(step)) + 4'd1)); // R7
endmodule

// File: rtl/onei_datapath.sv
module onei_datapath
  import onei_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 8,
  parameter int RESET_PC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  step_e             step,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] pc,
  output logic              pc_zero
);
  localparam logic [ADDR_W-1:0] PC_INIT = ADDR_W'(RESET_PC);
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);

  logic [ADDR_W-1:0] a_ptr, b_ptr, tgt;
  logic [DATA_W-1:0] a_val, res, diff;
  logic [ADDR_W-1:0] word_addr;
  logic              take;

  assign word_addr = mem_rdata[ADDR_W-1:0];

  onei_alu #(.DATA_W(DATA_W)) u_alu (
    .minuend   (mem_rdata),
    .subtrahend(a_val),
    .stored    (res),
    .diff      (diff),
    .le_zero   (take)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc    <= PC_INIT;
      a_ptr <= '0;
      b_ptr <= '0;
      tgt   <= '0;
      a_val <= '0;
      res   <= '0;
    end else begin
      case (step)
        ST_CA: begin
          a_ptr <= word_addr;
          pc    <= pc + PC_STEP;
        end
        ST_CVA: a_val <= mem_rdata;
        ST_CB: begin
          b_ptr <= word_addr;
          pc    <= pc + PC_STEP;
        end
        ST_CVB: res <= diff;
        ST_CP: begin
          tgt <= word_addr;
          pc  <= pc + PC_STEP;
        end
        ST_JMP: if (take) pc <= tgt;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (step)
      ST_FVA:        mem_addr = a_ptr;
      ST_FVB, ST_WB: mem_addr = b_ptr;
      default:       mem_addr = pc;
    endcase
  end

  assign mem_we    = (step == ST_WB);
  assign mem_wdata = res;
  assign pc_zero   = (pc == '0);

  AST_JMP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_JMP && take) |=> (pc == $past(tgt))); // R3
  AST_JMP_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_JMP && !take) |=> (pc == $past(pc))); // R4
  AST_PC_BUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_CA) |=> (pc == $past(pc) + PC_STEP)); // R4
endmodule

// File: rtl/onei_cpu.sv
module onei_cpu
  import onei_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 8,
  parameter int RESET_PC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted,
  output logic [ADDR_W-1:0] dbg_pc,
  output logic [3:0]        dbg_step
);
  step_e             step;
  logic              pc_zero;
  logic [ADDR_W-1:0] pc;

  onei_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .pc_zero(pc_zero),
    .step   (step),
    .halted (halted)
  );

  onei_datapath #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .RESET_PC(RESET_PC)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .mem_rdata(mem_rdata),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_we   (mem_we),
    .pc       (pc),
    .pc_zero  (pc_zero)
  );

  assign dbg_pc   = pc;
  assign dbg_step = 4'(step);

  AST_HALT_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_step == 4'd0 && dbg_pc == '0) |=> halted); // R6
  AST_NO_WRITE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we); // R6
  AST_PC_HELD_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(dbg_pc)); // R6
endmodule

// File: tb/tb_onei_cpu.sv
module tb_onei_cpu;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [AW-1:0] mem_addr, dbg_pc;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          mem_we, halted;
  logic [3:0]    dbg_step;

  logic [DW-1:0] img [DEPTH];
  logic [DW-1:0] mem [DEPTH];
  int checks = 0;
  int errors = 0;
  int wr_cnt;

  onei_cpu #(.DATA_W(DW), .ADDR_W(AW), .RESET_PC(1)) dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted),
    .dbg_pc(dbg_pc), .dbg_step(dbg_step)
  );

  // Memory model: loaded from img during reset, one-cycle read latency.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= img[i];
      mem_rdata <= '0;
      wr_cnt    <= 0;
    end else begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        wr_cnt        <= wr_cnt + 1;
      end
      mem_rdata <= mem[mem_addr];
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < DEPTH; i++) img[i] = '0;
  endtask

  task automatic put(input int at, input int a, input int b, input int p);
    img[at]   = DW'(a);
    img[at+1] = DW'(b);
    img[at+2] = DW'(p);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_to_halt(input string req);
    int n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(req, "halt reached", DW'(halted), DW'(1));
  endtask

  // R1, R7, R6: reset state, step order, halt via jump to 0
  task automatic t_reset_and_steps();
    clear_img();
    put(1, 0, 0, 0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "pc in reset", DW'(dbg_pc), DW'(1));
    chk("R1", "step in reset", DW'(dbg_step), DW'(0));
    chk("R1", "halted in reset", DW'(halted), DW'(0));
    chk("R1", "we in reset", DW'(mem_we), DW'(0));
    rst_n = 1'b1;
    for (int k = 0; k < 13; k++) begin
      chk("R7", $sformatf("step at cycle %0d", k), DW'(dbg_step), DW'(k % 12));
      @(negedge clk);
    end
    chk("R6", "halted after zero pc", DW'(halted), DW'(1));
    chk("R6", "step code when halted", DW'(dbg_step), DW'(15));
    repeat (40) @(negedge clk);
    chk("R6", "writes after halt", DW'(wr_cnt), DW'(1));
    chk("R6", "still halted", DW'(halted), DW'(1));
    chk("R6", "pc held at 0", DW'(dbg_pc), DW'(0));
  endtask

  // R2, R5: add through zero temporary
  task automatic t_add();
    clear_img();
    img[100] = 16'd5; img[101] = 16'd7; img[102] = 16'd0; img[103] = 16'd9;
    put(1, 100, 102, 4);
    put(4, 102, 101, 7);
    put(7, 103, 103, 0);
    do_reset();
    run_to_halt("R6");
    chk("R2", "add result", mem[101], 16'd12);
    chk("R2", "temp holds -A", mem[102], 16'hFFFB);
    chk("R5", "self-subtract clears", mem[103], 16'd0);
    chk("R7", "one write per instr (add)", DW'(wr_cnt), DW'(3));
    chk("R6", "pc at halt", DW'(dbg_pc), DW'(0));
  endtask

  // R2, R4: move built from three subtractions
  task automatic t_move();
    clear_img();
    img[110] = 16'hFED4; img[111] = 16'd1234; img[112] = 16'd0;
    put(1, 111, 111, 4);
    put(4, 110, 112, 7);
    put(7, 112, 111, 10);
    put(10, 113, 113, 0);
    do_reset();
    run_to_halt("R6");
    chk("R2", "move result", mem[111], 16'hFED4);
    chk("R4", "positive temp fallthrough", mem[112], 16'd300);
    chk("R7", "one write per instr (move)", DW'(wr_cnt), DW'(4));
  endtask

  // R3, R4: branch decision; marker at 10 runs only if branch taken,
  // halt-jump at 4 runs only if it falls through
  task automatic t_branch(input logic [DW-1:0] b0, input logic [DW-1:0] exp_b,
                          input logic taken, input string req);
    clear_img();
    img[120] = 16'd1; img[121] = b0; img[122] = 16'd7;
    img[125] = 16'd1; img[126] = 16'd0;
    put(1, 120, 121, 10);
    put(4, 122, 122, 0);
    put(10, 125, 126, 0);
    do_reset();
    run_to_halt("R6");
    chk("R2", "difference stored", mem[121], exp_b);
    chk(req, "marker at target", mem[126], taken ? 16'hFFFF : 16'd0);
    chk(req, "word at fallthrough", mem[122], taken ? 16'd7 : 16'd0);
    chk("R7", "write count", DW'(wr_cnt), DW'(2));
  endtask

  initial begin
    #1_600_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_img();
    t_reset_and_steps();
    t_add();
    t_move();
    t_branch(16'd3,     16'd2,     1'b0, "R4");
    t_branch(16'd0,     16'hFFFF,  1'b1, "R3");
    t_branch(16'd1,     16'd0,     1'b1, "R3");
    t_branch(16'h8000,  16'h7FFF,  1'b0, "R3");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule